// File: doc/BRIEF.md
# Reset Source Combiner with Cause Register

This block gathers every reset request of a small controller into a single system reset output and keeps a 16-bit register that records why the last reset or wake-up happened. The request inputs are a power-on pulse, a brown-out level, a start-up hold from an external delay sequencer, an active-low external reset pin, a software reset instruction, a watchdog expiry, a hard/soft trap pair, and an illegal-opcode or uninitialized-register fault. Power-mode events also arrive as inputs: entering sleep, entering idle, and the clear-watchdog instruction.

The external pin is synchronized and must stay low for a programmable number of consecutive clocks before it counts as a reset. A watchdog expiry resets the core only in run mode. In sleep or idle it only wakes the core and records the wake-up. Software can read and write the cause register through a simple write-enable port. A write never starts a reset. The block's own `rst_n` is asynchronous when asserted and is expected to be released synchronously to `clk` by the chip reset tree.

Top module: `reset_cause_hub`

## Requirements
- R1: `sys_rst_o` is registered. It is 1 after the edge following any cycle in which a reset request is present, and 0 after the first edge with none. The reset requests are power-on, brown-out, start-up hold, a qualified pin low, software reset, a run-mode watchdog expiry, a trap conflict, and an illegal-opcode fault. While `rst_n` is low, `sys_rst_o` is 1.
- R2: A power-on request, or `rst_n` low, sets the cause register to 16'h0003. This takes priority over writes and all other events.
- R3: Cause register bits:
  - bit 15 is trap conflict and bit 14 is the illegal-opcode fault.
  - bit 7 is the pin reset, bit 6 is the software reset, and bit 4 is the watchdog expiry.
  - bit 3 is was-in-sleep, bit 2 is was-in-idle, bit 1 is brown-out, and bit 0 is power-on.
  - bits 13, 10, 8 and 5 are plain read/write storage.
  - bits 12, 11 and 9 always read 0, so writing 16'hFFFF reads back 16'hE5FF.
- R4: A bus write loads the register on the next edge. It never asserts `sys_rst_o`, whatever bits it sets.
- R5: The pin passes through two synchronizer flops. Reset needs `PIN_MIN_LOW` consecutive synchronized low clocks. A shorter low pulse has no effect on the reset output or on bit 7. After the pin rises, reset drops 3 edges later.
- R6: A one-cycle software reset request sets bit 6 and holds `sys_rst_o` high for exactly one cycle.
- R7: A watchdog expiry in run mode sets bit 4 and resets. In sleep (or idle) it sets bit 4 and bit 3 (or bit 2), does not reset, and returns the mode to run.
- R8: A trap conflict (bit 15 plus reset) needs the hard and soft trap inputs in the same cycle. A single trap input has no effect.
- R9: Enter-sleep or enter-idle sets bit 3 or bit 2, respectively, and clears bit 4. Clear-watchdog clears bits 3 and 2.
- R10: Sources active in the same cycle all set their bits in that cycle. Hardware sets win over hardware clears, and both win over a same-cycle bus write.
- R11: Brown-out sets bit 1 and leaves bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| por_req_i | input | 1 | Power-on request |
| bor_req_i | input | 1 | Brown-out request, level |
| start_hold_i | input | 1 | Start-up delay still running, from the sequencer |
| pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| swrst_i | input | 1 | Software reset instruction executed |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| hard_trap_i | input | 1 | Hard trap raised |
| soft_trap_i | input | 1 | Soft trap raised |
| bad_op_i | input | 1 | Illegal opcode or uninitialized register use |
| enter_sleep_i | input | 1 | Sleep instruction executed |
| enter_idle_i | input | 1 | Idle instruction executed |
| clrwdt_i | input | 1 | Clear-watchdog instruction executed |
| wr_en_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 16 | Cause register write data |
| sys_rst_o | output | 1 | Combined system reset |
| cause_o | output | 16 | Cause register contents |

## Verification
A wrong power-mode state shows up at the ports on the first watchdog expiry after it: a wake-up becomes a reset, or a reset becomes a silent wake, and the sleep or idle bit appears on the wrong bit one edge later. A miscounted pin qualifier moves the rising edge of `sys_rst_o` by whole clocks, or lets a short glitch through, so the bench samples exactly at edge `PIN_MIN_LOW`+2 and +3. Errors in set/clear precedence appear in the cause register one edge after the colliding events, which the same-cycle vectors provoke directly.

// File: rtl/rcx_pkg.sv
package rcx_pkg;
  localparam int unsigned CAUSE_W = 16;

  localparam int unsigned B_POR   = 0;
  localparam int unsigned B_BOR   = 1;
  localparam int unsigned B_IDLE  = 2;
  localparam int unsigned B_SLEEP = 3;
  localparam int unsigned B_WDT   = 4;
  localparam int unsigned B_SW    = 6;
  localparam int unsigned B_PIN   = 7;
  localparam int unsigned B_BADOP = 14;
  localparam int unsigned B_TRAP  = 15;

  localparam logic [CAUSE_W-1:0] IMPL_MASK = 16'hE5FF;
  localparam logic [CAUSE_W-1:0] PWRON_VAL = 16'h0003;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_IDLE  = 2'd2
  } pmode_e;
endpackage

// File: rtl/pin_low_filter.sv
module pin_low_filter #(
  parameter int unsigned MIN_LOW     = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_n_i};
    cnt_d  = cnt_q;
    if (pin_s)                cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign qual_o = !pin_s && (cnt_q == CNT_TOP);

  // First synchronized low clock can never qualify a reset
  assert_short_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_s) |=> !qual_o);
endmodule

// File: rtl/cause_reg.sv
module cause_reg
  import rcx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_i,
  input  logic               wr_en_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic [CAUSE_W-1:0] clr_i,
  output logic [CAUSE_W-1:0] q_o
);
  logic [CAUSE_W-1:0] q_q, q_d, base;

  always_comb begin
    base = wr_en_i ? wr_data_i : q_q;
    q_d  = ((base & ~clr_i) | set_i) & IMPL_MASK;
    if (por_i) q_d = PWRON_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= PWRON_VAL;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  assert_pwron_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (q_o == PWRON_VAL));

  // Hardware sets survive clears and writes of the same cycle
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !por_i |=> ((q_o & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));
endmodule

// File: rtl/reset_cause_hub.sv
module reset_cause_hub
  import rcx_pkg::*;
#(
  parameter int unsigned PIN_MIN_LOW = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_req_i,
  input  logic        bor_req_i,
  input  logic        start_hold_i,
  input  logic        pin_n_i,
  input  logic        swrst_i,
  input  logic        wdt_expire_i,
  input  logic        hard_trap_i,
  input  logic        soft_trap_i,
  input  logic        bad_op_i,
  input  logic        enter_sleep_i,
  input  logic        enter_idle_i,
  input  logic        clrwdt_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic        sys_rst_o,
  output logic [15:0] cause_o
);
  logic               pin_qual, trap_hit, wdt_run, wdt_wake, any_src;
  logic               rst_q, rst_d;
  pmode_e             mode_q, mode_d;
  logic [CAUSE_W-1:0] set_v, clr_v;

  pin_low_filter #(.MIN_LOW(PIN_MIN_LOW), .SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n_i(pin_n_i), .qual_o(pin_qual)
  );

  always_comb begin
    trap_hit = hard_trap_i && soft_trap_i;
    wdt_run  = wdt_expire_i && (mode_q == PM_RUN);
    wdt_wake = wdt_expire_i && (mode_q != PM_RUN);
    any_src  = por_req_i | bor_req_i | start_hold_i | pin_qual | swrst_i
             | wdt_run | trap_hit | bad_op_i;
    rst_d    = any_src;

    set_v = '0;
    set_v[B_BOR]   = bor_req_i;
    set_v[B_PIN]   = pin_qual;
    set_v[B_SW]    = swrst_i;
    set_v[B_WDT]   = wdt_expire_i;
    set_v[B_SLEEP] = enter_sleep_i | (wdt_wake && mode_q == PM_SLEEP);
    set_v[B_IDLE]  = enter_idle_i  | (wdt_wake && mode_q == PM_IDLE);
    set_v[B_TRAP]  = trap_hit;
    set_v[B_BADOP] = bad_op_i;

    clr_v = '0;
    clr_v[B_WDT]   = enter_sleep_i | enter_idle_i;
    clr_v[B_SLEEP] = clrwdt_i;
    clr_v[B_IDLE]  = clrwdt_i;

    mode_d = mode_q;
    if (any_src || wdt_wake) mode_d = PM_RUN;
    else if (enter_sleep_i)  mode_d = PM_SLEEP;
    else if (enter_idle_i)   mode_d = PM_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      mode_q <= PM_RUN;
    end else begin
      rst_q  <= rst_d;
      mode_q <= mode_d;
    end
  end

  cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .por_i(por_req_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .set_i(set_v), .clr_i(clr_v), .q_o(cause_o)
  );

  assign sys_rst_o = rst_q;

  assert_sw_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_i |=> (sys_rst_o && cause_o[B_SW]));

  assert_wdt_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire_i && mode_q != PM_RUN && !por_req_i && !bor_req_i && !start_hold_i
     && !pin_qual && !swrst_i && !hard_trap_i && !bad_op_i)
    |=> (!sys_rst_o && cause_o[B_WDT]));

  assert_single_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hard_trap_i ^ soft_trap_i) && !por_req_i && !wr_en_i)
    |=> (cause_o[B_TRAP] == $past(cause_o[B_TRAP])));

  assert_bor_keeps_por_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_req_i && !por_req_i && !wr_en_i)
    |=> (cause_o[B_BOR] && cause_o[B_POR] == $past(cause_o[B_POR])));
endmodule

// File: tb/reset_cause_hub_bench.sv
module reset_cause_hub_bench;
  localparam int MIN_LOW = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic por_req_i, bor_req_i, start_hold_i, pin_n_i, swrst_i, wdt_expire_i;
  logic hard_trap_i, soft_trap_i, bad_op_i, enter_sleep_i, enter_idle_i, clrwdt_i;
  logic wr_en_i;
  logic [15:0] wr_data_i;
  logic sys_rst_o;
  logic [15:0] cause_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  reset_cause_hub #(.PIN_MIN_LOW(MIN_LOW), .SYNC_STAGES(2)) u_reset_cause_hub (
    .clk(clk), .rst_n(rst_n), .por_req_i(por_req_i), .bor_req_i(bor_req_i),
    .start_hold_i(start_hold_i), .pin_n_i(pin_n_i), .swrst_i(swrst_i),
    .wdt_expire_i(wdt_expire_i), .hard_trap_i(hard_trap_i), .soft_trap_i(soft_trap_i),
    .bad_op_i(bad_op_i), .enter_sleep_i(enter_sleep_i), .enter_idle_i(enter_idle_i),
    .clrwdt_i(clrwdt_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .sys_rst_o(sys_rst_o), .cause_o(cause_o)
  );

  // {req, preset, events[por,bor,sw,wdt,hard,soft,bad,sleep,idle,clrwdt], rst, cause}
  localparam int NV = 16;
  localparam logic [46:0] VEC [NV] = '{
    {4'd6,  16'h0000, 10'b0010000000, 1'b1, 16'h0040}, // R6 software reset
    {4'd7,  16'h0000, 10'b0001000000, 1'b1, 16'h0010}, // R7 watchdog in run
    {4'd8,  16'h0000, 10'b0000100000, 1'b0, 16'h0000}, // R8 lone hard trap
    {4'd8,  16'h0000, 10'b0000110000, 1'b1, 16'h8000}, // R8 trap conflict
    {4'd1,  16'h0000, 10'b0000001000, 1'b1, 16'h4000}, // R1 illegal opcode
    {4'd11, 16'h0000, 10'b0100000000, 1'b1, 16'h0002}, // R11 brown-out
    {4'd9,  16'h0010, 10'b0000000100, 1'b0, 16'h0008}, // R9 enter sleep
    {4'd7,  16'h0000, 10'b0001000000, 1'b0, 16'h0018}, // R7 wake from sleep
    {4'd9,  16'h0010, 10'b0000000010, 1'b0, 16'h0004}, // R9 enter idle
    {4'd7,  16'h0000, 10'b0001000000, 1'b0, 16'h0014}, // R7 wake from idle
    {4'd9,  16'h000C, 10'b0000000001, 1'b0, 16'h0000}, // R9 clear-watchdog
    {4'd2,  16'hFFFF, 10'b1000000000, 1'b1, 16'h0003}, // R2 power-on
    {4'd10, 16'h0000, 10'b0110111000, 1'b1, 16'hC042}, // R10 several sources
    {4'd3,  16'h0020, 10'b0000000000, 1'b0, 16'h0020}, // R3 storage bit
    {4'd11, 16'h0001, 10'b0100000000, 1'b1, 16'h0003}, // R11 keeps power-on bit
    {4'd10, 16'h0000, 10'b0001000100, 1'b1, 16'h0018}  // R10 set beats clear
  };

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    por_req_i = 0; bor_req_i = 0; start_hold_i = 0; swrst_i = 0; wdt_expire_i = 0;
    hard_trap_i = 0; soft_trap_i = 0; bad_op_i = 0; enter_sleep_i = 0;
    enter_idle_i = 0; clrwdt_i = 0; wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic put_events(input logic [9:0] ev);
    {por_req_i, bor_req_i, swrst_i, wdt_expire_i, hard_trap_i, soft_trap_i,
     bad_op_i, enter_sleep_i, enter_idle_i, clrwdt_i} = ev;
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk); idle_inputs(); wr_en_i = 1; wr_data_i = v;
    @(negedge clk); idle_inputs();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    bit seen;
    rst_n = 0; pin_n_i = 1; idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1", "rst during reset", {15'd0, sys_rst_o}, 16'd1);
    chk("R2", "cause during reset", cause_o, 16'h0003);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "rst released", {15'd0, sys_rst_o}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      write_reg(v[42:27]);
      put_events(v[26:17]);
      @(negedge clk);
      idle_inputs();
      n_chk++;
      if (sys_rst_o !== v[16] || cause_o !== v[15:0]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual rst=%b cause=%h expected rst=%b cause=%h",
                 v[46:43], i, sys_rst_o, cause_o, v[16], v[15:0]);
      end
      @(negedge clk);
    end

    // R4 / R3: write all ones, no reset, unimplemented bits zero
    @(negedge clk); wr_en_i = 1; wr_data_i = 16'hFFFF;
    @(negedge clk); idle_inputs();
    chk("R3", "masked readback", cause_o, 16'hE5FF);
    chk("R4", "write no reset", {15'd0, sys_rst_o}, 16'd0);

    // R10 write with same-cycle software reset; R6 one-cycle pulse
    wr_en_i = 1; wr_data_i = 16'h0000; swrst_i = 1;
    @(negedge clk); idle_inputs();
    chk("R10", "write vs set", cause_o, 16'h0040);
    chk("R6", "sw reset on", {15'd0, sys_rst_o}, 16'd1);
    @(negedge clk);
    chk("R6", "sw reset one cycle", {15'd0, sys_rst_o}, 16'd0);

    // R1 start-up hold
    start_hold_i = 1;
    repeat (3) @(negedge clk);
    chk("R1", "hold keeps reset", {15'd0, sys_rst_o}, 16'd1);
    start_hold_i = 0;
    @(negedge clk);
    chk("R1", "hold released", {15'd0, sys_rst_o}, 16'd0);

    // R5 short pin pulse ignored
    write_reg(16'h0000);
    seen = 0;
    pin_n_i = 0;
    repeat (MIN_LOW / 2) begin @(negedge clk); if (sys_rst_o) seen = 1; end
    pin_n_i = 1;
    repeat (6) begin @(negedge clk); if (sys_rst_o) seen = 1; end
    chk("R5", "short pulse no reset", {15'd0, seen}, 16'd0);
    chk("R5", "short pulse no flag", cause_o, 16'h0000);

    // R5 long pin pulse: reset at edge MIN_LOW+3
    pin_n_i = 0;
    repeat (MIN_LOW + 2) @(negedge clk);
    chk("R5", "not yet qualified", {15'd0, sys_rst_o}, 16'd0);
    @(negedge clk);
    chk("R5", "pin reset on", {15'd0, sys_rst_o}, 16'd1);
    chk("R5", "pin flag", cause_o, 16'h0080);
    pin_n_i = 1;
    repeat (2) @(negedge clk);
    chk("R5", "release in flight", {15'd0, sys_rst_o}, 16'd1);
    @(negedge clk);
    chk("R5", "pin reset off", {15'd0, sys_rst_o}, 16'd0);

    finish_run();
  end
endmodule